// File: doc/BRIEF.md
# Framed Serial Command Decoder with Parameter Readback

This block sits behind a serial pin decoder that has already turned pulse widths into bits. Each bit arrives with a one-cycle strobe. The block keeps the 38 most recent bits in a sliding window. It accepts a frame when the window is bracketed by the fixed start and end marks and carries the fixed tag pair. It then splits the frame into a mode field, a select field and an 8-bit data field, and acts on them in the same clock edge that samples the last bit.

There are three kinds of command:

- **Read.** The stored parameter picked by the select field goes into an 8-bit shift register. Its MSB drives a digital output, and each later falling-edge strobe of the input clock shifts it one place. The eighth such strobe closes the readback.
- **Sense level.** A configuration frame sets a volatile low/normal sense-current level.
- **Programming.** Every other valid frame is passed on as a one-cycle programming command carrying its three fields.

Top module: `fcmd_decoder`

## Requirements
- R1: After synchronous reset, `rd_oe`, `rd_dout` and `prog_vld` are 0.
- R2: A frame is 38 bits, MSB first: start mark `1000_0000_0001`, 2-bit mode, 2-bit select, tag `10`, 8-bit data, end mark `0111_1111_1110`. A valid frame takes effect at the clock edge that samples its 38th bit strobe.
- R3: A frame with a wrong start mark, end mark or tag causes no change of any output. A valid frame that follows it directly is still accepted, because the window resynchronises.
- R4: A valid frame with mode `11` starts a readback. The select field picks fuse slot s (bits `[8s+7:8s]` of `fuse_vals`) and the data field is ignored. In the same edge `rd_oe` goes to 1 and `rd_dout` shows bit 7 of the padded value.
- R5: During readback, the k-th `fall_stb` pulse (k = 1..7) makes `rd_dout` show bit 7-k of the padded value. The pulse takes effect at the edge that samples it.
- R6: The eighth `fall_stb` pulse after entry ends readback: `rd_oe` and `rd_dout` go to 0.
- R7: Slot lengths are 3, 7, 8 and 8 bits for selects 00, 01, 10 and 11. Fuse bits above a slot's length read back as 0, so slot 00 appears on pulses 5 to 7 with its LSB on pulse 7.
- R8: A valid frame with mode `00` and select `00` sets `sense_low` to bit 0 of the data field. The other data bits have no effect.
- R9: `sense_low` resets to 0 (normal level), and a reset returns it to 0 after it was set.
- R10: Any other valid frame raises `prog_vld` for exactly one cycle, with `prog_mode`, `prog_sel` and `prog_data` equal to the frame's fields.
- R11: `fall_stb` pulses outside readback leave `rd_oe` and `rd_dout` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Strobe: one decoded serial bit is present |
| bit_val | input | 1 | Value of the decoded bit |
| fall_stb | input | 1 | One-cycle pulse per falling edge of the serial input clock |
| fuse_vals | input | 32 | Stored parameters, slot s in bits [8s+7:8s] |
| rd_dout | output | 1 | Readback data bit |
| rd_oe | output | 1 | Readback drives the output pin |
| sense_low | output | 1 | 1 selects the low sense current |
| prog_vld | output | 1 | One-cycle programming command strobe |
| prog_mode | output | 2 | Mode field of the programming command |
| prog_sel | output | 2 | Select field of the programming command |
| prog_data | output | 8 | Data field of the programming command |

## Verification
Every effect of a frame is due one cycle after its last bit is driven: the readback load, the sense level and the programming strobe all register at the edge that samples the 38th strobe. Each readback shift is also due one cycle after its `fall_stb` pulse. The bench drives inputs one time unit after a rising edge and samples one time unit after the next edge, so each check reads exactly the cycle in which a result first appears. Random frames are spread over random idle gaps and preceded by random junk bits, which tests that timing is keyed to the strobes and not to a fixed cycle count.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

    localparam int DATA_W  = 8;
    localparam int SEL_W   = 2;
    localparam int MODE_W  = 2;
    localparam int TAG_W   = 2;
    localparam int MARK_W  = 12;
    localparam int NSLOT   = 1 << SEL_W;
    localparam int FRAME_W = 2 * MARK_W + MODE_W + SEL_W + TAG_W + DATA_W;

    // field offsets inside the received window (bit 0 = last bit received)
    localparam int DATA_LO  = MARK_W;
    localparam int TAG_LO   = DATA_LO + DATA_W;
    localparam int SEL_LO   = TAG_LO + TAG_W;
    localparam int MODE_LO  = SEL_LO + SEL_W;
    localparam int START_LO = MODE_LO + MODE_W;

    localparam logic [MARK_W-1:0] START_MARK = 12'b1000_0000_0001;
    localparam logic [MARK_W-1:0] END_MARK   = 12'b0111_1111_1110;
    localparam logic [TAG_W-1:0]  TAG_MARK   = 2'b10;

    localparam logic [MODE_W-1:0] MODE_READ  = 2'b11;
    localparam logic [MODE_W-1:0] MODE_CFG   = 2'b00;
    localparam logic [SEL_W-1:0]  SEL_SENSE  = 2'b00;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] data;
    } cmd_t;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_READ,
        ACT_SENSE,
        ACT_PROG
    } act_e;

    // significant width of each stored parameter slot
    function automatic int slot_len(input logic [SEL_W-1:0] sel);
        case (sel)
            2'b00:   return 3;
            2'b01:   return 7;
            default: return 8;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] pad_mask(input logic [SEL_W-1:0] sel);
        logic [DATA_W-1:0] m;
        int len;
        len = slot_len(sel);
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = (i < len);
        end
        return m;
    endfunction

    function automatic act_e classify(input cmd_t c);
        if (c.mode == MODE_READ)
            return ACT_READ;
        else if (c.mode == MODE_CFG && c.sel == SEL_SENSE)
            return ACT_SENSE;
        else
            return ACT_PROG;
    endfunction

endpackage

// File: rtl/fcmd_frame_rx.sv
module fcmd_frame_rx
    import fcmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    input  logic bit_val,
    output logic acc,
    output cmd_t cmd
);

    localparam int FILL_W = $clog2(FRAME_W + 1);
    localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] win;
    logic [FRAME_W-1:0] nxt_win;
    logic [FILL_W-1:0]  fill;
    logic               full;
    logic               marks_ok;

    always_comb begin
        nxt_win  = {win[FRAME_W-2:0], bit_val};
        full     = (fill == FILL_LAST);
        marks_ok = (nxt_win[START_LO +: MARK_W] == START_MARK) &&
                   (nxt_win[TAG_LO   +: TAG_W]  == TAG_MARK)   &&
                   (nxt_win[0        +: MARK_W] == END_MARK);
        acc      = bit_vld && full && marks_ok;
        cmd.mode = nxt_win[MODE_LO +: MODE_W];
        cmd.sel  = nxt_win[SEL_LO  +: SEL_W];
        cmd.data = nxt_win[DATA_LO +: DATA_W];
    end

    // fill counts bits since the last accepted frame, saturating one short
    // of a whole frame so that the next strobe can complete a window
    always_ff @(posedge clk) begin
        if (rst) begin
            win  <= '0;
            fill <= '0;
        end else if (bit_vld) begin
            win <= nxt_win;
            if (acc)
                fill <= '0;
            else if (!full)
                fill <= fill + 1'b1;
        end
    end

    // R2: accepted frames never overlap, so two accepts are never adjacent
    a_r2_no_double_accept: assert property (@(posedge clk) disable iff (rst)
        acc |=> !acc);

endmodule

// File: rtl/fcmd_readback.sv
module fcmd_readback
    import fcmd_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic [SEL_W-1:0]          sel,
    input  logic [NSLOT*DATA_W-1:0]   fuse_vals,
    input  logic                      fall_stb,
    output logic                      dout,
    output logic                      oe
);

    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] slots [NSLOT];
    logic [DATA_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic              active;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign slots[s] = fuse_vals[s*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '0;
            cnt    <= '0;
            active <= 1'b0;
        end else if (load) begin
            sh     <= slots[sel] & pad_mask(sel);
            cnt    <= '0;
            active <= 1'b1;
        end else if (active && fall_stb) begin
            sh <= {sh[DATA_W-2:0], 1'b0};
            if (cnt == CNT_LAST)
                active <= 1'b0;
            else
                cnt <= cnt + 1'b1;
        end
    end

    assign dout = active & sh[DATA_W-1];
    assign oe   = active;

    // R4: a load always opens the readback
    a_r4_load_opens: assert property (@(posedge clk) disable iff (rst)
        load |=> oe);

    // R5: a shift pulse before the last one moves the next bit to the pin
    a_r5_shift_next: assert property (@(posedge clk) disable iff (rst)
        (active && fall_stb && !load && cnt != CNT_LAST) |=> (dout == $past(sh[DATA_W-2])));

    // R6: the final pulse closes the readback
    a_r6_last_closes: assert property (@(posedge clk) disable iff (rst)
        (active && fall_stb && !load && cnt == CNT_LAST) |=> (!oe && !dout));

    // R11: idle pulses never reopen the readback
    a_r11_idle_stays: assert property (@(posedge clk) disable iff (rst)
        (!active && !load) |=> !oe);

endmodule

// File: rtl/fcmd_decoder.sv
module fcmd_decoder
    import fcmd_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_vld,
    input  logic                    bit_val,
    input  logic                    fall_stb,
    input  logic [NSLOT*DATA_W-1:0] fuse_vals,
    output logic                    rd_dout,
    output logic                    rd_oe,
    output logic                    sense_low,
    output logic                    prog_vld,
    output logic [MODE_W-1:0]       prog_mode,
    output logic [SEL_W-1:0]        prog_sel,
    output logic [DATA_W-1:0]       prog_data
);

    logic acc;
    cmd_t cmd;
    act_e act;
    logic do_read;
    logic do_sense;
    logic do_prog;

    fcmd_frame_rx u_rx (
        .clk     (clk),
        .rst     (rst),
        .bit_vld (bit_vld),
        .bit_val (bit_val),
        .acc     (acc),
        .cmd     (cmd)
    );

    always_comb begin
        act      = acc ? classify(cmd) : ACT_NONE;
        do_read  = (act == ACT_READ);
        do_sense = (act == ACT_SENSE);
        do_prog  = (act == ACT_PROG);
    end

    fcmd_readback u_rb (
        .clk       (clk),
        .rst       (rst),
        .load      (do_read),
        .sel       (cmd.sel),
        .fuse_vals (fuse_vals),
        .fall_stb  (fall_stb),
        .dout      (rd_dout),
        .oe        (rd_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sense_low <= 1'b0;
        end else if (do_sense) begin
            sense_low <= cmd.data[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_vld  <= 1'b0;
            prog_mode <= '0;
            prog_sel  <= '0;
            prog_data <= '0;
        end else begin
            prog_vld <= do_prog;
            if (do_prog) begin
                prog_mode <= cmd.mode;
                prog_sel  <= cmd.sel;
                prog_data <= cmd.data;
            end
        end
    end

    // R8: the sense level moves only on a sense frame
    a_r8_sense_hold: assert property (@(posedge clk) disable iff (rst)
        !do_sense |=> $stable(sense_low));

    // R10: the programming strobe lasts a single cycle
    a_r10_prog_pulse: assert property (@(posedge clk) disable iff (rst)
        prog_vld |=> !prog_vld);

    // R3: without an accepted frame no command output is produced
    a_r3_no_frame_quiet: assert property (@(posedge clk) disable iff (rst)
        !acc |=> !prog_vld);

endmodule

// File: tb/fcmd_decoder_test.sv
module fcmd_decoder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_vld = 1'b0;
    logic        bit_val = 1'b0;
    logic        fall_stb = 1'b0;
    logic [31:0] fuse_vals = '0;
    logic        rd_dout, rd_oe, sense_low, prog_vld;
    logic [1:0]  prog_mode, prog_sel;
    logic [7:0]  prog_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fcmd_decoder uut (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_val(bit_val),
        .fall_stb(fall_stb), .fuse_vals(fuse_vals),
        .rd_dout(rd_dout), .rd_oe(rd_oe), .sense_low(sense_low),
        .prog_vld(prog_vld), .prog_mode(prog_mode), .prog_sel(prog_sel),
        .prog_data(prog_data)
    );

    function automatic logic [37:0] mk_frame(input logic [1:0] m, input logic [1:0] s,
                                             input logic [7:0] d);
        return {12'b1000_0000_0001, m, s, 2'b10, d, 12'b0111_1111_1110};
    endfunction

    function automatic logic [7:0] exp_value(input logic [1:0] s, input logic [31:0] f);
        logic [7:0] raw;
        raw = f[s*8 +: 8];
        case (s)
            2'b00:   return raw & 8'h07;
            2'b01:   return raw & 8'h7F;
            default: return raw;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic send_bits(input logic [37:0] fr, input int maxgap);
        for (int i = 37; i >= 0; i--) begin
            bit_vld = 1'b1;
            bit_val = fr[i];
            tick();
            bit_vld = 1'b0;
            if (maxgap > 0 && i > 0) begin
                int g = $urandom_range(maxgap, 0);
                for (int k = 0; k < g; k++) tick();
            end
        end
    endtask

    task automatic send_junk(input int n);
        for (int i = 0; i < n; i++) begin
            bit_vld = 1'b1;
            bit_val = $urandom_range(1, 0);
            tick();
        end
        bit_vld = 1'b0;
    endtask

    task automatic pulse_fall();
        fall_stb = 1'b1;
        tick();
        fall_stb = 1'b0;
    endtask

    task automatic read_check(input logic [1:0] s, input logic [7:0] f4, input int gap);
        logic [7:0] v;
        v = exp_value(s, fuse_vals);
        send_bits(mk_frame(2'b11, s, f4), gap);
        chk("R4 read entry oe", rd_oe, 1);
        chk("R4 read entry msb", rd_dout, v[7]);
        for (int k = 1; k <= 7; k++) begin
            int g = $urandom_range(gap, 0);
            for (int j = 0; j < g; j++) tick();
            pulse_fall();
            chk("R5 shifted bit", rd_dout, v[7-k]);
            chk("R5 oe held", rd_oe, 1);
        end
        pulse_fall();
        chk("R6 eighth pulse oe", rd_oe, 0);
        chk("R6 eighth pulse dout", rd_dout, 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 / R9 reset state
        chk("R1 oe after reset", rd_oe, 0);
        chk("R1 dout after reset", rd_dout, 0);
        chk("R1 prog_vld after reset", prog_vld, 0);
        chk("R9 sense default", sense_low, 0);

        // R11 idle falling pulses
        repeat (3) pulse_fall();
        chk("R11 idle pulses oe", rd_oe, 0);
        chk("R11 idle pulses dout", rd_dout, 0);

        // R8 sense select, other data bits don't care
        send_bits(mk_frame(2'b00, 2'b00, 8'b1010_1011), 0);
        chk("R8 sense low set", sense_low, 1);
        chk("R2 sense frame no prog", prog_vld, 0);
        send_bits(mk_frame(2'b00, 2'b00, 8'b1111_1110), 0);
        chk("R8 sense normal", sense_low, 0);

        // R3 corrupted frames: start, tag, end
        send_bits(mk_frame(2'b00, 2'b00, 8'h01) ^ (38'h1 << 36), 0);
        chk("R3 bad start", sense_low, 0);
        send_bits(mk_frame(2'b00, 2'b00, 8'h01) ^ (38'h1 << 20), 0);
        chk("R3 bad tag", sense_low, 0);
        send_bits(mk_frame(2'b01, 2'b01, 8'h33) ^ (38'h1 << 5), 0);
        chk("R3 bad end no prog", prog_vld, 0);
        send_bits(mk_frame(2'b00, 2'b00, 8'h01), 0);
        chk("R3 resync after bad", sense_low, 1);

        // R9 reset returns sense to normal
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R9 sense cleared by reset", sense_low, 0);

        // R10 programming command
        send_bits(mk_frame(2'b01, 2'b10, 8'hA5), 0);
        chk("R10 prog_vld", prog_vld, 1);
        chk("R10 prog_mode", prog_mode, 2'b01);
        chk("R10 prog_sel", prog_sel, 2'b10);
        chk("R10 prog_data", prog_data, 8'hA5);
        tick();
        chk("R10 single cycle", prog_vld, 0);
        send_bits(mk_frame(2'b00, 2'b11, 8'h5C), 2);
        chk("R10 cfg non-sense prog", prog_vld, 1);
        chk("R10 cfg data", prog_data, 8'h5C);
        chk("R8 cfg non-sense keeps sense", sense_low, 0);

        // R7 zero padding: all fuse bits set, slot 0 reads 0000_0111
        fuse_vals = 32'hFFFF_FFFF;
        read_check(2'b00, 8'hFF, 0);
        read_check(2'b01, 8'h00, 0);
        chk("R7 slot0 padded", exp_value(2'b00, fuse_vals), 8'h07);
        pulse_fall();
        chk("R11 pulse after read", rd_oe, 0);

        // random frames, gaps and junk prefixes
        for (int t = 0; t < 40; t++) begin
            logic [1:0] s;
            fuse_vals = $urandom();
            s = 2'($urandom_range(3, 0));
            send_junk($urandom_range(15, 0));
            read_check(s, 8'($urandom()), 3);
            if (t % 4 == 0) begin
                logic [7:0] d = 8'($urandom());
                send_junk($urandom_range(9, 0));
                send_bits(mk_frame(2'b00, 2'b00, d), 2);
                chk("R8 random sense", sense_low, d[0]);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule